// File: doc/BRIEF.md
# Parallel Sampling ADC Interface Controller

This block drives a 12-bit parallel-output sampling A/D converter with a start-convert / end-of-conversion handshake. A free-running rate timer asks for a sample once per programmed period. For each sample the controller raises a start pulse of programmable width. It waits for the synchronized EOC line to go high and then fall, and pulls the converter's active-low output enable down for a programmable settling window. At the end of that window it latches the 12 data bits.

The converter has no pipeline latency, so every latched word belongs to the start pulse just before it. The controller turns the offset-binary code into two's complement by inverting the top bit, and it offers the word downstream over a valid/ready handshake. While EOC is high no new start is ever issued, because a restart would spoil the conversion. The first conversions after reset are run and thrown away to cover warmup. Missing or stuck EOC edges end in a sticky timeout flag. Samples that arrive while the output is still occupied are dropped and counted.

All timing settings are counted in system clock cycles and held steady while `run` is high.

Top module: `adc_sampler_ctrl`

## Requirements
- R1: After reset, `adc_start` is low, `adc_oe_n` is high, `out_valid` is low, `err_timeout` is low and `overrun_cnt` is zero.
- R2: Each start pulse stays high for max(`cfg_pulse_w`, MIN_PULSE) clock cycles, where MIN_PULSE defaults to 5.
- R3: While `run` is high and every conversion finishes in time, rising edges of `adc_start` are spaced max(`cfg_period`, MIN_PERIOD) cycles apart, where MIN_PERIOD defaults to 32.
- R4: No start rises while the synchronized EOC level is high. A start that falls due during that time is delayed until EOC is low.
- R5: `adc_oe_n` goes low only after a detected EOC falling edge. It stays low for max(`cfg_settle`, 1) cycles and is never low while `adc_start` is high. The data bits are latched on the edge that ends this window.
- R6: Each output word is the latched 12-bit code with bit 11 (the MSB) inverted, so offset binary becomes two's complement. It comes from the conversion started by the start pulse just before it.
- R7: The first `cfg_warmup` completed conversions after reset produce no output word.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: A capture that finds `out_valid` high and `out_ready` low is dropped. `overrun_cnt` goes up by one, saturating at its maximum, and the held word is kept.
- R10: If EOC does not go high within `cfg_rise_to` cycles after the start pulse ends, `err_timeout` is set and the controller returns to idle. Later starts still happen.
- R11: If EOC does not fall within `cfg_fall_to` cycles after it went high, `err_timeout` is set and the controller returns to idle. `err_timeout` stays set until reset.
- R12: While `run` is low, no start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables periodic sampling |
| cfg_period | input | 16 | Sample period in cycles (clamped up to MIN_PERIOD) |
| cfg_pulse_w | input | 16 | Start pulse width in cycles (clamped up to MIN_PULSE) |
| cfg_settle | input | 16 | Output-enable window before capture, in cycles (minimum 1) |
| cfg_rise_to | input | 16 | Timeout for EOC going high, in cycles |
| cfg_fall_to | input | 16 | Timeout for EOC falling, in cycles |
| cfg_warmup | input | 8 | Number of conversions discarded after reset |
| adc_start | output | 1 | Start-convert pulse to the converter |
| adc_eoc | input | 1 | Asynchronous end-of-conversion from the converter |
| adc_oe_n | output | 1 | Active-low output enable to the converter |
| adc_data | input | 12 | Converter data bus, offset binary, bit 11 is MSB |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 12 | Sample in two's complement |
| overrun_cnt | output | 8 | Saturating count of dropped samples |
| err_timeout | output | 1 | Sticky EOC timeout flag |

## Verification
The assertions check on every cycle that a start never rises over a high synchronized EOC. They also check that start pulses are never shorter than MIN_PULSE, that the output enable and the start are never active together, that a stalled word holds still, that the timeout flag never clears, and that the overrun count never goes down. Only the bench scenarios can show the rest: exact pulse widths and periods, including the clamping, and the settle window length. The same holds for the bit remap, the warmup discard, and the pairing of each word with its own conversion. Those scenarios also cover dropping under back-pressure, the two timeout paths with recovery, and the resumption of sampling after EOC is released from a stuck-high state.

// File: rtl/adc_ctrl_pkg.sv
// Shared types for the ADC interface controller.
package adc_ctrl_pkg;
    // Conversion sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_SETTLE
    } conv_state_t;
endpackage

// File: rtl/adc_eoc_sync.sv
// Two-flop synchronizer for the asynchronous EOC line, plus falling-edge
// detection on the synchronized level. Assumes EOC pulses last several cycles.
module adc_eoc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_async,
    output logic eoc_lvl,
    output logic eoc_fall
);
    logic meta_q, sync_q, prev_q;

    // Two-stage resynchronization, then one delay stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= eoc_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign eoc_lvl  = sync_q;
    assign eoc_fall = prev_q & ~sync_q;
endmodule

// File: rtl/adc_rate_timer.sv
// Free-running sample-rate divider. Gives a one-cycle tick once per effective
// period, which is the programmed period clamped up to MIN_PERIOD.
module adc_rate_timer #(
    parameter int CNT_W      = 16,
    parameter int MIN_PERIOD = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cfg_period,
    output logic             tick
);
    localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);

    logic [CNT_W-1:0] eff_period;
    logic [CNT_W-1:0] cnt_q;

    // Clamp the requested period to the minimum conversion time
    always_comb eff_period = (cfg_period < MIN_P) ? MIN_P : cfg_period;

    assign tick = run && (cnt_q == eff_period - 1'b1);

    // Count cycles within the period; hold at zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/adc_conv_seq.sv
// Conversion sequencer: start pulse, EOC high/low wait with timeouts,
// output-enable settle window, capture strobe, and warmup discard.
// Assumes configuration is steady while run is high.
module adc_conv_seq
    import adc_ctrl_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int WARM_W    = 8,
    parameter int MIN_PULSE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              eoc_lvl,
    input  logic              eoc_fall,
    input  logic [CNT_W-1:0]  cfg_pulse_w,
    input  logic [CNT_W-1:0]  cfg_settle,
    input  logic [CNT_W-1:0]  cfg_rise_to,
    input  logic [CNT_W-1:0]  cfg_fall_to,
    input  logic [WARM_W-1:0] cfg_warmup,
    output logic              adc_start,
    output logic              adc_oe_n,
    output logic              cap_stb,
    output logic              err_timeout
);
    localparam logic [CNT_W-1:0] MIN_PW = CNT_W'(MIN_PULSE);

    conv_state_t      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_pw, eff_settle;
    logic [WARM_W-1:0] warm_q;
    logic             pend_q, go, settle_end, warm_done;

    // Effective pulse width and settle length after clamping
    always_comb begin
        eff_pw     = (cfg_pulse_w < MIN_PW) ? MIN_PW : cfg_pulse_w;
        eff_settle = (cfg_settle == '0) ? CNT_W'(1) : cfg_settle;
    end

    assign go         = (state_q == ST_IDLE) && run && pend_q && !eoc_lvl;
    assign settle_end = (state_q == ST_SETTLE) && (cnt_q == eff_settle - 1'b1);
    assign warm_done  = (warm_q >= cfg_warmup);
    assign cap_stb    = settle_end && warm_done;

    // Remember a requested sample until a start can be issued
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pend_q <= 1'b0;
        else if (tick)      pend_q <= 1'b1;
        else if (go)        pend_q <= 1'b0;
    end

    // Count completed conversions until warmup has passed
    always_ff @(posedge clk) begin
        if (!rst_n)                       warm_q <= '0;
        else if (settle_end && !warm_done) warm_q <= warm_q + 1'b1;
    end

    // Main sequencer with its step counter and output drives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            adc_start   <= 1'b0;
            adc_oe_n    <= 1'b1;
            err_timeout <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        state_q   <= ST_PULSE;
                        adc_start <= 1'b1;
                        cnt_q     <= '0;
                    end
                end
                ST_PULSE: begin
                    if (cnt_q == eff_pw - 1'b1) begin
                        state_q   <= ST_WAIT_HI;
                        adc_start <= 1'b0;
                        cnt_q     <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WAIT_HI: begin
                    if (eoc_lvl) begin
                        state_q <= ST_WAIT_LO;
                        cnt_q   <= '0;
                    end else if (cnt_q >= cfg_rise_to) begin
                        state_q     <= ST_IDLE;
                        err_timeout <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WAIT_LO: begin
                    if (eoc_fall) begin
                        state_q  <= ST_SETTLE;
                        adc_oe_n <= 1'b0;
                        cnt_q    <= '0;
                    end else if (cnt_q >= cfg_fall_to) begin
                        state_q     <= ST_IDLE;
                        err_timeout <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (settle_end) begin
                        state_q  <= ST_IDLE;
                        adc_oe_n <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_out_stage.sv
// Output register: offset binary to two's complement, valid/ready holding,
// and a saturating overrun counter for samples dropped under back-pressure.
module adc_out_stage #(
    parameter int DATA_W = 12,
    parameter int OVR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_stb,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [OVR_W-1:0]  overrun_cnt
);
    logic blocked;
    assign blocked = out_valid && !out_ready;

    // Load a new word, or drop it and count when the held word is stalled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            overrun_cnt <= '0;
        end else if (cap_stb && blocked) begin
            if (overrun_cnt != '1) overrun_cnt <= overrun_cnt + 1'b1;
        end else if (cap_stb) begin
            out_valid <= 1'b1;
            out_data  <= {~adc_data[DATA_W-1], adc_data[DATA_W-2:0]};
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_sampler_ctrl.sv
// Top: parallel sampling ADC interface controller. Ties the EOC synchronizer,
// rate timer, conversion sequencer and output stage together.
module adc_sampler_ctrl #(
    parameter int DATA_W     = 12,
    parameter int CNT_W      = 16,
    parameter int WARM_W     = 8,
    parameter int OVR_W      = 8,
    parameter int MIN_PULSE  = 5,
    parameter int MIN_PERIOD = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CNT_W-1:0]  cfg_period,
    input  logic [CNT_W-1:0]  cfg_pulse_w,
    input  logic [CNT_W-1:0]  cfg_settle,
    input  logic [CNT_W-1:0]  cfg_rise_to,
    input  logic [CNT_W-1:0]  cfg_fall_to,
    input  logic [WARM_W-1:0] cfg_warmup,
    output logic              adc_start,
    input  logic              adc_eoc,
    output logic              adc_oe_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [OVR_W-1:0]  overrun_cnt,
    output logic              err_timeout
);
    logic eoc_q, eoc_fall, tick, cap_stb;

    adc_eoc_sync u_sync (
        .clk(clk), .rst_n(rst_n), .eoc_async(adc_eoc),
        .eoc_lvl(eoc_q), .eoc_fall(eoc_fall)
    );

    adc_rate_timer #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_period(cfg_period), .tick(tick)
    );

    adc_conv_seq #(.CNT_W(CNT_W), .WARM_W(WARM_W), .MIN_PULSE(MIN_PULSE)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .eoc_lvl(eoc_q), .eoc_fall(eoc_fall),
        .cfg_pulse_w(cfg_pulse_w), .cfg_settle(cfg_settle),
        .cfg_rise_to(cfg_rise_to), .cfg_fall_to(cfg_fall_to),
        .cfg_warmup(cfg_warmup),
        .adc_start(adc_start), .adc_oe_n(adc_oe_n),
        .cap_stb(cap_stb), .err_timeout(err_timeout)
    );

    adc_out_stage #(.DATA_W(DATA_W), .OVR_W(OVR_W)) u_out (
        .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .adc_data(adc_data),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .overrun_cnt(overrun_cnt)
    );
endmodule

// File: rtl/adc_sampler_ctrl_chk.sv
// Protocol checker for adc_sampler_ctrl, bound to every instance of the top.
module adc_sampler_ctrl_chk #(
    parameter int DATA_W    = 12,
    parameter int OVR_W     = 8,
    parameter int MIN_PULSE = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_start,
    input logic              adc_oe_n,
    input logic              eoc_q,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [OVR_W-1:0]  overrun_cnt,
    input logic              err_timeout
);
    logic [15:0] hi_len;

    // Length of the current start pulse in cycles, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                         hi_len <= '0;
        else if (adc_start && hi_len != '1) hi_len <= hi_len + 1'b1;
        else if (!adc_start)                hi_len <= '0;
    end

    assert_pulse_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_start) |-> hi_len >= 16'(MIN_PULSE));

    assert_no_start_on_eoc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_start) |-> !$past(eoc_q));

    assert_oe_apart_from_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_start && !adc_oe_n));

    assert_hold_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_overrun_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> overrun_cnt >= $past(overrun_cnt));

    assert_error_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> err_timeout);
endmodule

bind adc_sampler_ctrl adc_sampler_ctrl_chk #(
    .DATA_W(DATA_W), .OVR_W(OVR_W), .MIN_PULSE(MIN_PULSE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_oe_n(adc_oe_n),
    .eoc_q(eoc_q), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .overrun_cnt(overrun_cnt), .err_timeout(err_timeout)
);

// File: tb/adc_sampler_ctrl_tb.sv
// Directed bench with a behavioural converter model.
module adc_sampler_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] cfg_period = 16'd50, cfg_pulse_w = 16'd10, cfg_settle = 16'd3;
    logic [15:0] cfg_rise_to = 16'd20, cfg_fall_to = 16'd40;
    logic [7:0]  cfg_warmup = 8'd0;
    logic        adc_start, adc_oe_n, out_valid, err_timeout;
    logic        out_ready = 1'b1;
    logic        eoc = 1'b0;
    logic [11:0] out_data;
    logic [7:0]  overrun_cnt;
    logic [11:0] word = 12'h000;
    wire  [11:0] adc_bus;

    int total = 0, bad = 0, cyc = 0;
    int model_mode = 0;   // 0 normal, 1 no EOC, 2 EOC stuck high
    int kk = 0, viol = 0;
    int nstart = 0, last_rise = 0, last_per = 0, last_pw = 0, pw_run = 0;
    int oe_run = 0, last_oe = 0, nrec = 0;
    logic prev_s = 1'b0;
    logic [11:0] rec [0:15];

    always #5 clk = ~clk;

    assign adc_bus = adc_oe_n ? 12'bz : word;

    adc_sampler_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_period(cfg_period),
        .cfg_pulse_w(cfg_pulse_w), .cfg_settle(cfg_settle),
        .cfg_rise_to(cfg_rise_to), .cfg_fall_to(cfg_fall_to),
        .cfg_warmup(cfg_warmup), .adc_start(adc_start), .adc_eoc(eoc),
        .adc_oe_n(adc_oe_n), .adc_data(adc_bus), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .overrun_cnt(overrun_cnt),
        .err_timeout(err_timeout)
    );

    function automatic logic [11:0] code_of(int k);
        return 12'((k * 773 + 291) & 12'hFFF);
    endfunction

    // Converter model: acts on the start rising edge, no pipeline latency
    always @(posedge adc_start) begin
        if (eoc) viol++;
        if (model_mode == 0) begin
            automatic int idx = kk;
            kk++;
            #20 eoc = 1'b1;
            #150 word = code_of(idx);
            eoc = 1'b0;
        end else if (model_mode == 2) begin
            kk++;
            #20 eoc = 1'b1;
        end else begin
            kk++;
        end
    end

    // Monitors sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (adc_start && !prev_s) begin
                last_per  = cyc - last_rise;
                last_rise = cyc;
                nstart++;
            end
            if (adc_start) pw_run++;
            else if (pw_run > 0) begin last_pw = pw_run; pw_run = 0; end
            if (!adc_oe_n) oe_run++;
            else if (oe_run > 0) begin last_oe = oe_run; oe_run = 0; end
            if (out_valid && out_ready && nrec < 16) begin
                rec[nrec] = out_data;
                nrec++;
            end
        end
        prev_s = adc_start;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        run = 1'b0;
        rst_n = 1'b0;
        repeat (30) @(negedge clk);
        model_mode = 0; eoc = 1'b0; kk = 0; viol = 0;
        nstart = 0; nrec = 0; last_per = 0; last_pw = 0; last_oe = 0;
        pw_run = 0; oe_run = 0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_rec(input int n);
        for (int i = 0; i < 5000 && nrec < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(adc_start == 1'b0, "R1 start", adc_start, 0);
        check(adc_oe_n == 1'b1, "R1 oe_n", adc_oe_n, 1);
        check(out_valid == 1'b0, "R1 valid", out_valid, 0);
        check(err_timeout == 1'b0, "R1 err", err_timeout, 0);
        check(overrun_cnt == 8'd0, "R1 overrun", overrun_cnt, 0);
    endtask

    task automatic t_stream();
        cfg_period = 16'd50; cfg_pulse_w = 16'd10; cfg_settle = 16'd3;
        cfg_warmup = 8'd2; out_ready = 1'b1;
        do_reset();
        run = 1'b1;
        wait_rec(4);
        check(nrec >= 4, "R6 count", nrec, 4);
        for (int i = 0; i < 4; i++)
            check(rec[i] == (code_of(i + 2) ^ 12'h800), "R7 R6 word",
                  rec[i], code_of(i + 2) ^ 12'h800);
        check(last_pw == 10, "R2 width", last_pw, 10);
        check(last_per == 50, "R3 period", last_per, 50);
        check(last_oe == 3, "R5 settle", last_oe, 3);
        check(viol == 0, "R4 restarts", viol, 0);
    endtask

    task automatic t_clamp();
        cfg_period = 16'd5; cfg_pulse_w = 16'd2; cfg_settle = 16'd0;
        cfg_warmup = 8'd0;
        do_reset();
        run = 1'b1;
        wait_rec(3);
        check(last_per == 32, "R3 clamp", last_per, 32);
        check(last_pw == 5, "R2 clamp", last_pw, 5);
        check(last_oe == 1, "R5 min settle", last_oe, 1);
        check(rec[0] == (code_of(0) ^ 12'h800), "R6 first", rec[0], code_of(0) ^ 12'h800);
    endtask

    task automatic t_backpressure();
        cfg_period = 16'd40; cfg_pulse_w = 16'd10; cfg_settle = 16'd2;
        cfg_warmup = 8'd0; out_ready = 1'b0;
        do_reset();
        run = 1'b1;
        for (int i = 0; i < 5000 && overrun_cnt < 8'd3; i++) @(negedge clk);
        check(overrun_cnt == 8'd3, "R9 count", overrun_cnt, 3);
        check(out_valid == 1'b1, "R8 valid held", out_valid, 1);
        check(out_data == (code_of(0) ^ 12'h800), "R9 kept word", out_data, code_of(0) ^ 12'h800);
        out_ready = 1'b1;
        wait_rec(2);
        check(rec[1] == (code_of(4) ^ 12'h800), "R6 latest", rec[1], code_of(4) ^ 12'h800);
        check(overrun_cnt == 8'd3, "R9 no extra", overrun_cnt, 3);
    endtask

    task automatic t_rise_timeout();
        int n0;
        cfg_period = 16'd60; cfg_rise_to = 16'd20; cfg_warmup = 8'd0;
        do_reset();
        model_mode = 1;
        run = 1'b1;
        repeat (120) @(negedge clk);
        check(err_timeout == 1'b1, "R10 flag", err_timeout, 1);
        n0 = nstart;
        repeat (130) @(negedge clk);
        check(nstart > n0, "R10 resumes", nstart, n0 + 1);
        check(nrec == 0, "R10 no word", nrec, 0);
    endtask

    task automatic t_fall_timeout();
        int n0;
        cfg_period = 16'd40; cfg_fall_to = 16'd40; cfg_warmup = 8'd0;
        do_reset();
        model_mode = 2;
        run = 1'b1;
        repeat (150) @(negedge clk);
        check(err_timeout == 1'b1, "R11 flag", err_timeout, 1);
        n0 = nstart;
        repeat (300) @(negedge clk);
        check(nstart == n0, "R4 held off", nstart, n0);
        model_mode = 0;
        eoc = 1'b0;
        repeat (120) @(negedge clk);
        check(nstart > n0, "R4 resumes", nstart, n0 + 1);
        check(err_timeout == 1'b1, "R11 sticky", err_timeout, 1);
        check(viol == 0, "R4 restarts", viol, 0);
    endtask

    task automatic t_run_low();
        cfg_period = 16'd40;
        do_reset();
        repeat (200) @(negedge clk);
        check(nstart == 0, "R12 idle", nstart, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_stream();
        t_clamp();
        t_backpressure();
        t_rise_timeout();
        t_fall_timeout();
        t_run_low();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule